// File: doc/BRIEF.md
# Trap Delegation and Privilege Controller

This block holds the current privilege level of a 32-bit RISC-V hart and the trap-handling CSRs of the machine and supervisor levels. When the core reports a trap (exception or interrupt, cause code, optional trap value, faulting pc), the block decides whether machine or supervisor mode takes it. It updates the cause, epc, tval and status fields of that level and drives a pc redirect to the trap vector in the same cycle.

The block also carries out MRET and SRET. It checks that the current privilege allows the return and flags an illegal instruction when it does not. Software reaches the registers through a single-cycle CSR port. Reads are combinational, writes take effect at the next clock edge, and addresses that are not implemented raise an illegal flag.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset the privilege is machine (`priv_o` = 3), the status word reads 0x1800 (previous machine privilege = 3), and both delegation registers, all cause/epc/tval registers and both vectors read zero.
- R2: A trap taken below machine mode tests bit `cause` of the interrupt delegation register (0x303) for an interrupt, or of the exception delegation register (0x302) for an exception. A set bit sends the trap to supervisor mode; a clear bit sends it to machine mode.
- R3: A trap taken in machine mode always goes to machine mode, whatever the delegation bits hold.
- R4: A machine-level trap has these effects:
  - mcause (0x342) gets the interrupt flag in bit 31 and the code in the low bits, and mepc (0x341) gets the trapping pc.
  - MPP (status bits 12:11) gets the old privilege.
  - MPIE (bit 7) gets the old MIE (bit 3), then MIE clears.
  - Privilege becomes 3.
- R5: A supervisor-level trap has these effects:
  - scause (0x142) gets the interrupt flag and code, and sepc (0x141) gets the trapping pc.
  - SPP (bit 8) gets the old privilege.
  - SPIE (bit 5) gets the old SIE (bit 1), then SIE clears.
  - Privilege becomes 1.
- R6: The trap value is written to mtval (0x343) or stval (0x143) only when `trap_has_val_i` is high. Otherwise the register keeps its value.
- R7: During a trap, `redirect_valid_o` is high in the same cycle and `redirect_pc_o` is the target vector (mtvec 0x305 or stvec 0x105) with bits 1:0 forced to zero.
- R8: MRET below machine mode raises `xret_illegal_o` with no redirect and no state change. Otherwise MRET redirects to mepc, sets privilege to the old MPP, clears MPP to 0, copies MPIE into MIE and sets MPIE.
- R9: SRET in user mode raises `xret_illegal_o` with no redirect and no state change. Otherwise SRET redirects to sepc, sets privilege to 1 if SPP was set and to 0 otherwise, clears SPP, copies SPIE into SIE and sets SPIE.
- R10: The status word has these read and write rules:
  - It exposes only bits 1, 3, 5, 7, 8 and 12:11; all other bits read zero.
  - The supervisor view at 0x100 reads and writes only bits 1, 5 and 8.
  - A write of 2 to MPP leaves MPP unchanged.
  - stvec 0x105, scounteren 0x106, sscratch 0x140 and mscratch 0x340 read back as written.
  - 0x301, 0x304, 0x344, 0x104 and 0x144 read as zero without a flag.
- R11: A read or write of any other CSR address raises `csr_illegal_o` in the same cycle, and such a write changes no register.
- R12: When several actions arrive in one cycle, a trap wins over MRET/SRET, and MRET/SRET win over a CSR write. The losing xRET neither redirects nor flags illegal, and the losing CSR write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_valid_i | input | 1 | Trap request this cycle |
| trap_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause_i | input | CAUSE_W | Cause code |
| trap_has_val_i | input | 1 | Trap value is supplied |
| trap_val_i | input | XLEN | Trap value |
| trap_pc_i | input | XLEN | Pc of the trapping instruction |
| mret_i | input | 1 | MRET executed |
| sret_i | input | 1 | SRET executed |
| csr_re_i | input | 1 | CSR read access |
| csr_we_i | input | 1 | CSR write access |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data |
| csr_illegal_o | output | 1 | Access to an unimplemented CSR |
| xret_illegal_o | output | 1 | MRET/SRET not allowed at current privilege |
| redirect_valid_o | output | 1 | Pc redirect this cycle |
| redirect_pc_o | output | XLEN | Redirect target |
| priv_o | output | 2 | Current privilege (3 M, 1 S, 0 U) |

## Verification
The assertions assume that the core raises at most one trap per cycle, and that the cause code has already been checked against the width of the delegation registers. They also assume that MRET and SRET arrive as single-cycle pulses that are released after the clock edge that applies them. The bench keeps to these rules. It drives every request for exactly one cycle, starting at a falling edge, and uses only cause codes below 32. It reaches user and supervisor mode only through MRET/SRET or through traps, so the privilege value 2 never appears. The one case with simultaneous requests is the deliberate priority scenario.

// File: rtl/priv_pkg.sv
package priv_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;

  localparam logic [11:0] A_SSTATUS  = 12'h100;
  localparam logic [11:0] A_SIE      = 12'h104;
  localparam logic [11:0] A_STVEC    = 12'h105;
  localparam logic [11:0] A_SCNTEN   = 12'h106;
  localparam logic [11:0] A_SSCRATCH = 12'h140;
  localparam logic [11:0] A_SEPC     = 12'h141;
  localparam logic [11:0] A_SCAUSE   = 12'h142;
  localparam logic [11:0] A_STVAL    = 12'h143;
  localparam logic [11:0] A_SIP      = 12'h144;
  localparam logic [11:0] A_MSTATUS  = 12'h300;
  localparam logic [11:0] A_MISA     = 12'h301;
  localparam logic [11:0] A_MEDELEG  = 12'h302;
  localparam logic [11:0] A_MIDELEG  = 12'h303;
  localparam logic [11:0] A_MIE      = 12'h304;
  localparam logic [11:0] A_MTVEC    = 12'h305;
  localparam logic [11:0] A_MSCRATCH = 12'h340;
  localparam logic [11:0] A_MEPC     = 12'h341;
  localparam logic [11:0] A_MCAUSE   = 12'h342;
  localparam logic [11:0] A_MTVAL    = 12'h343;
  localparam logic [11:0] A_MIP      = 12'h344;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_ZERO,
    SEL_MSTATUS, SEL_MEDELEG, SEL_MIDELEG, SEL_MTVEC, SEL_MSCRATCH,
    SEL_MEPC, SEL_MCAUSE, SEL_MTVAL,
    SEL_SSTATUS, SEL_STVEC, SEL_SCNTEN, SEL_SSCRATCH,
    SEL_SEPC, SEL_SCAUSE, SEL_STVAL
  } csr_sel_e;
endpackage

// File: rtl/priv_csr_decode.sv
module priv_csr_decode
  import priv_pkg::*;
(
  input  logic [11:0] addr_i,
  output csr_sel_e    sel_o
);
  always_comb begin
    case (addr_i)
      A_MSTATUS:  sel_o = SEL_MSTATUS;
      A_MEDELEG:  sel_o = SEL_MEDELEG;
      A_MIDELEG:  sel_o = SEL_MIDELEG;
      A_MTVEC:    sel_o = SEL_MTVEC;
      A_MSCRATCH: sel_o = SEL_MSCRATCH;
      A_MEPC:     sel_o = SEL_MEPC;
      A_MCAUSE:   sel_o = SEL_MCAUSE;
      A_MTVAL:    sel_o = SEL_MTVAL;
      A_SSTATUS:  sel_o = SEL_SSTATUS;
      A_STVEC:    sel_o = SEL_STVEC;
      A_SCNTEN:   sel_o = SEL_SCNTEN;
      A_SSCRATCH: sel_o = SEL_SSCRATCH;
      A_SEPC:     sel_o = SEL_SEPC;
      A_SCAUSE:   sel_o = SEL_SCAUSE;
      A_STVAL:    sel_o = SEL_STVAL;
      // interrupt enable/pending and isa live outside this block
      A_MISA, A_MIE, A_MIP, A_SIE, A_SIP: sel_o = SEL_ZERO;
      default:    sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/priv_trap_route.sv
module priv_trap_route
  import priv_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic [1:0]         priv_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    medeleg_i,
  input  logic [XLEN-1:0]    mideleg_i,
  input  logic [XLEN-1:0]    mtvec_i,
  input  logic [XLEN-1:0]    stvec_i,
  output logic               to_s_o,
  output logic [XLEN-1:0]    vec_o
);
  logic [XLEN-1:0] deleg;
  logic [XLEN-1:0] tvec;

  assign deleg  = irq_i ? mideleg_i : medeleg_i;
  assign to_s_o = (priv_i != PRIV_M) && deleg[cause_i];
  assign tvec   = to_s_o ? stvec_i : mtvec_i;
  assign vec_o  = {tvec[XLEN-1:2], 2'b00};
endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
  import priv_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_valid_i,
  input  logic               trap_irq_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic               trap_has_val_i,
  input  logic [XLEN-1:0]    trap_val_i,
  input  logic [XLEN-1:0]    trap_pc_i,
  input  logic               mret_i,
  input  logic               sret_i,
  input  logic               csr_re_i,
  input  logic               csr_we_i,
  input  logic [11:0]        csr_addr_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic               csr_illegal_o,
  output logic               xret_illegal_o,
  output logic               redirect_valid_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [1:0]         priv_o
);
  localparam int CODE_PAD = XLEN - 1 - CAUSE_W;
  localparam logic [XLEN-1:0] SMASK =
    XLEN'((1 << ST_SIE) | (1 << ST_SPIE) | (1 << ST_SPP));

  logic [1:0]      priv_q, mpp_q;
  logic            sie_q, mie_q, spie_q, mpie_q, spp_q;
  logic [XLEN-1:0] medeleg_q, mideleg_q, mtvec_q, stvec_q;
  logic [XLEN-1:0] mscratch_q, sscratch_q, scnten_q;
  logic [XLEN-1:0] mepc_q, sepc_q, mcause_q, scause_q, mtval_q, stval_q;

  csr_sel_e        sel;
  logic            to_s;
  logic [XLEN-1:0] vec, status_rd, cause_word;
  logic            mret_ok, sret_ok, csr_wr;

  priv_csr_decode i_dec (.addr_i(csr_addr_i), .sel_o(sel));

  priv_trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_route (
    .priv_i   (priv_q),
    .irq_i    (trap_irq_i),
    .cause_i  (trap_cause_i),
    .medeleg_i(medeleg_q),
    .mideleg_i(mideleg_q),
    .mtvec_i  (mtvec_q),
    .stvec_i  (stvec_q),
    .to_s_o   (to_s),
    .vec_o    (vec)
  );

  // trap > mret > sret > csr write
  assign mret_ok = mret_i && !trap_valid_i && priv_q == PRIV_M;
  assign sret_ok = sret_i && !mret_i && !trap_valid_i && priv_q != PRIV_U;
  assign xret_illegal_o = !trap_valid_i &&
    ((mret_i && priv_q != PRIV_M) || (sret_i && !mret_i && priv_q == PRIV_U));
  assign csr_wr = csr_we_i && sel != SEL_NONE && !trap_valid_i && !mret_ok && !sret_ok;
  assign csr_illegal_o = (csr_we_i || csr_re_i) && sel == SEL_NONE;

  assign redirect_valid_o = trap_valid_i || mret_ok || sret_ok;
  assign redirect_pc_o    = trap_valid_i ? vec : (mret_ok ? mepc_q : sepc_q);
  assign priv_o           = priv_q;
  assign cause_word       = {trap_irq_i, {CODE_PAD{1'b0}}, trap_cause_i};

  always_comb begin
    status_rd          = '0;
    status_rd[ST_SIE]  = sie_q;
    status_rd[ST_MIE]  = mie_q;
    status_rd[ST_SPIE] = spie_q;
    status_rd[ST_MPIE] = mpie_q;
    status_rd[ST_SPP]  = spp_q;
    status_rd[ST_MPP +: 2] = mpp_q;
  end

  always_comb begin
    case (sel)
      SEL_MSTATUS:  csr_rdata_o = status_rd;
      SEL_SSTATUS:  csr_rdata_o = status_rd & SMASK;
      SEL_MEDELEG:  csr_rdata_o = medeleg_q;
      SEL_MIDELEG:  csr_rdata_o = mideleg_q;
      SEL_MTVEC:    csr_rdata_o = mtvec_q;
      SEL_STVEC:    csr_rdata_o = stvec_q;
      SEL_MSCRATCH: csr_rdata_o = mscratch_q;
      SEL_SSCRATCH: csr_rdata_o = sscratch_q;
      SEL_SCNTEN:   csr_rdata_o = scnten_q;
      SEL_MEPC:     csr_rdata_o = mepc_q;
      SEL_SEPC:     csr_rdata_o = sepc_q;
      SEL_MCAUSE:   csr_rdata_o = mcause_q;
      SEL_SCAUSE:   csr_rdata_o = scause_q;
      SEL_MTVAL:    csr_rdata_o = mtval_q;
      SEL_STVAL:    csr_rdata_o = stval_q;
      default:      csr_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q <= PRIV_M;  mpp_q <= PRIV_M;
      sie_q <= 1'b0; mie_q <= 1'b0; spie_q <= 1'b0; mpie_q <= 1'b0; spp_q <= 1'b0;
      medeleg_q <= '0; mideleg_q <= '0; mtvec_q <= '0; stvec_q <= '0;
      mscratch_q <= '0; sscratch_q <= '0; scnten_q <= '0;
      mepc_q <= '0; sepc_q <= '0; mcause_q <= '0; scause_q <= '0;
      mtval_q <= '0; stval_q <= '0;
    end else if (trap_valid_i) begin
      if (to_s) begin
        scause_q <= cause_word;
        sepc_q   <= trap_pc_i;
        if (trap_has_val_i) stval_q <= trap_val_i;
        spp_q  <= priv_q[0];
        spie_q <= sie_q;
        sie_q  <= 1'b0;
        priv_q <= PRIV_S;
      end else begin
        mcause_q <= cause_word;
        mepc_q   <= trap_pc_i;
        if (trap_has_val_i) mtval_q <= trap_val_i;
        mpp_q  <= priv_q;
        mpie_q <= mie_q;
        mie_q  <= 1'b0;
        priv_q <= PRIV_M;
      end
    end else if (mret_ok) begin
      priv_q <= mpp_q;
      mpp_q  <= PRIV_U;
      mie_q  <= mpie_q;
      mpie_q <= 1'b1;
    end else if (sret_ok) begin
      priv_q <= spp_q ? PRIV_S : PRIV_U;
      spp_q  <= 1'b0;
      sie_q  <= spie_q;
      spie_q <= 1'b1;
    end else if (csr_wr) begin
      case (sel)
        SEL_MSTATUS: begin
          sie_q  <= csr_wdata_i[ST_SIE];
          mie_q  <= csr_wdata_i[ST_MIE];
          spie_q <= csr_wdata_i[ST_SPIE];
          mpie_q <= csr_wdata_i[ST_MPIE];
          spp_q  <= csr_wdata_i[ST_SPP];
          if (csr_wdata_i[ST_MPP +: 2] != 2'd2) mpp_q <= csr_wdata_i[ST_MPP +: 2];
        end
        SEL_SSTATUS: begin
          sie_q  <= csr_wdata_i[ST_SIE];
          spie_q <= csr_wdata_i[ST_SPIE];
          spp_q  <= csr_wdata_i[ST_SPP];
        end
        SEL_MEDELEG:  medeleg_q  <= csr_wdata_i;
        SEL_MIDELEG:  mideleg_q  <= csr_wdata_i;
        SEL_MTVEC:    mtvec_q    <= csr_wdata_i;
        SEL_STVEC:    stvec_q    <= csr_wdata_i;
        SEL_MSCRATCH: mscratch_q <= csr_wdata_i;
        SEL_SSCRATCH: sscratch_q <= csr_wdata_i;
        SEL_SCNTEN:   scnten_q   <= csr_wdata_i;
        SEL_MEPC:     mepc_q     <= csr_wdata_i;
        SEL_SEPC:     sepc_q     <= csr_wdata_i;
        SEL_MCAUSE:   mcause_q   <= csr_wdata_i;
        SEL_SCAUSE:   scause_q   <= csr_wdata_i;
        SEL_MTVAL:    mtval_q    <= csr_wdata_i;
        SEL_STVAL:    stval_q    <= csr_wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/priv_trap_ctrl_chk.sv
module priv_trap_ctrl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            trap_valid_i,
  input logic            mret_i,
  input logic            sret_i,
  input logic            csr_re_i,
  input logic            csr_we_i,
  input logic [XLEN-1:0] trap_pc_i,
  input logic [XLEN-1:0] mepc_q,
  input logic [XLEN-1:0] sepc_q,
  input logic [1:0]      priv_o,
  input logic            redirect_valid_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic            xret_illegal_o,
  input logic            csr_illegal_o
);
  p_trap_redirect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |-> redirect_valid_o && redirect_pc_o[1:0] == 2'b00);

  p_m_stays_m_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && priv_o == 2'd3 |=> priv_o == 2'd3);

  p_trap_epc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> ((priv_o == 2'd3) ? mepc_q : sepc_q) == $past(trap_pc_i));

  p_trap_no_user_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> priv_o != 2'd0);

  p_mret_illegal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mret_i && !trap_valid_i && priv_o != 2'd3 |-> xret_illegal_o && !redirect_valid_o);

  p_mret_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mret_i && !trap_valid_i && priv_o != 2'd3 |=> $stable(priv_o));

  p_priv_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_o != 2'd2);

  p_sret_illegal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sret_i && !mret_i && !trap_valid_i && priv_o == 2'd0 |-> xret_illegal_o && !redirect_valid_o);

  p_csr_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> csr_re_i || csr_we_i);

  p_trap_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && (mret_i || sret_i) |-> !xret_illegal_o);
endmodule

bind priv_trap_ctrl priv_trap_ctrl_chk #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_priv_trap_ctrl.sv
module test_priv_trap_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 0, trap_irq = 0, trap_has_val = 0;
  logic [4:0]  trap_cause = '0;
  logic [31:0] trap_val = '0, trap_pc = '0;
  logic        mret = 0, sret = 0, csr_re = 0, csr_we = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata, redirect_pc;
  logic        csr_illegal, xret_illegal, redirect_valid;
  logic [1:0]  priv;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  priv_trap_ctrl i_priv_trap_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .trap_valid_i(trap_valid), .trap_irq_i(trap_irq), .trap_cause_i(trap_cause),
    .trap_has_val_i(trap_has_val), .trap_val_i(trap_val), .trap_pc_i(trap_pc),
    .mret_i(mret), .sret_i(sret),
    .csr_re_i(csr_re), .csr_we_i(csr_we), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata), .csr_illegal_o(csr_illegal), .xret_illegal_o(xret_illegal),
    .redirect_valid_o(redirect_valid), .redirect_pc_o(redirect_pc), .priv_o(priv)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk); csr_re = 1; csr_addr = a;
    #1 chk(req, $sformatf("csr %h", a), csr_rdata, exp);
    chk(req, "csr flag", {31'b0, csr_illegal}, 32'd0);
    csr_re = 0;
  endtask

  task automatic trap(input string req, input logic irq, input logic [4:0] c, input logic hv,
                      input logic [31:0] v, input logic [31:0] pc, input logic [31:0] exp_vec);
    @(negedge clk);
    trap_valid = 1; trap_irq = irq; trap_cause = c; trap_has_val = hv; trap_val = v; trap_pc = pc;
    #1 chk(req, "redirect valid", {31'b0, redirect_valid}, 32'd1);
    chk(req, "redirect pc", redirect_pc, exp_vec);
    @(negedge clk); trap_valid = 0; trap_has_val = 0;
  endtask

  task automatic xret(input string req, input logic is_m, input logic ok, input logic [31:0] exp_pc);
    @(negedge clk); mret = is_m; sret = !is_m;
    #1 chk(req, "xret illegal", {31'b0, xret_illegal}, {31'b0, !ok});
    chk(req, "redirect valid", {31'b0, redirect_valid}, {31'b0, ok});
    if (ok) chk(req, "redirect pc", redirect_pc, exp_pc);
    @(negedge clk); mret = 0; sret = 0;
  endtask

  task automatic priv_chk(input string req, input logic [1:0] exp);
    @(negedge clk); chk(req, "priv", {30'b0, priv}, {30'b0, exp});
  endtask

  task automatic t_reset;
    priv_chk("R1", 2'd3);
    rd_chk("R1", 12'h300, 32'h1800);
    rd_chk("R1", 12'h302, 0);
    rd_chk("R1", 12'h303, 0);
    rd_chk("R1", 12'h342, 0);
    rd_chk("R1", 12'h305, 0);
  endtask

  task automatic t_csr_map;
    wr(12'h305, 32'h1003); rd_chk("R10", 12'h305, 32'h1003);
    wr(12'h105, 32'h2001); rd_chk("R10", 12'h105, 32'h2001);
    wr(12'h106, 32'h7);    rd_chk("R10", 12'h106, 32'h7);
    wr(12'h140, 32'hA5A5); rd_chk("R10", 12'h140, 32'hA5A5);
    wr(12'h300, 32'hFFFFFFFF); rd_chk("R10", 12'h300, 32'h19AA);
    rd_chk("R10", 12'h100, 32'h122);
    wr(12'h100, 32'h0); rd_chk("R10", 12'h300, 32'h1888);
    wr(12'h300, 32'h1000); rd_chk("R10", 12'h300, 32'h1800);
    rd_chk("R10", 12'h301, 0);
    rd_chk("R10", 12'h144, 0);
  endtask

  task automatic t_illegal;
    wr(12'h340, 32'h11);
    @(negedge clk); csr_re = 1; csr_addr = 12'h7C0;
    #1 chk("R11", "read flag", {31'b0, csr_illegal}, 32'd1);
    csr_re = 0;
    @(negedge clk); csr_we = 1; csr_addr = 12'h345; csr_wdata = 32'hFF;
    #1 chk("R11", "write flag", {31'b0, csr_illegal}, 32'd1);
    @(negedge clk); csr_we = 0;
    rd_chk("R11", 12'h340, 32'h11);
    rd_chk("R11", 12'h343, 0);
  endtask

  task automatic t_trap_m;
    wr(12'h302, 32'hFFFFFFFF);
    wr(12'h300, 32'h1808);
    trap("R3", 1'b0, 5'd2, 1'b1, 32'hDEAD, 32'h80000100, 32'h1000);
    priv_chk("R3", 2'd3);
    rd_chk("R4", 12'h342, 32'h2);
    rd_chk("R4", 12'h341, 32'h80000100);
    rd_chk("R6", 12'h343, 32'hDEAD);
    rd_chk("R4", 12'h300, 32'h1880);
  endtask

  task automatic t_mret;
    wr(12'h341, 32'h400);
    wr(12'h300, 32'h0080);
    xret("R8", 1'b1, 1'b1, 32'h400);
    priv_chk("R8", 2'd0);
    rd_chk("R8", 12'h300, 32'h88);
    xret("R8", 1'b1, 1'b0, 0);
    priv_chk("R8", 2'd0);
    xret("R9", 1'b0, 1'b0, 0);
    priv_chk("R9", 2'd0);
    rd_chk("R9", 12'h300, 32'h88);
  endtask

  task automatic t_trap_s;
    wr(12'h143, 32'h1234);
    wr(12'h300, 32'h008A);
    trap("R2", 1'b0, 5'd8, 1'b0, 32'h55, 32'h404, 32'h2000);
    priv_chk("R5", 2'd1);
    rd_chk("R5", 12'h142, 32'h8);
    rd_chk("R5", 12'h141, 32'h404);
    rd_chk("R6", 12'h143, 32'h1234);
    rd_chk("R5", 12'h300, 32'hA8);
    rd_chk("R5", 12'h343, 32'hDEAD);
  endtask

  task automatic t_irq_m;
    trap("R2", 1'b1, 5'd5, 1'b0, 32'h66, 32'h2010, 32'h1000);
    priv_chk("R2", 2'd3);
    rd_chk("R4", 12'h342, 32'h80000005);
    rd_chk("R4", 12'h341, 32'h2010);
    rd_chk("R4", 12'h300, 32'h8A0);
    rd_chk("R6", 12'h343, 32'hDEAD);
  endtask

  task automatic t_sret_m;
    xret("R9", 1'b0, 1'b1, 32'h404);
    priv_chk("R9", 2'd0);
    rd_chk("R9", 12'h300, 32'h8A2);
  endtask

  task automatic t_irq_s;
    wr(12'h303, 32'h200);
    trap("R2", 1'b1, 5'd9, 1'b1, 32'h77, 32'h500, 32'h2000);
    priv_chk("R5", 2'd1);
    rd_chk("R5", 12'h142, 32'h80000009);
    rd_chk("R6", 12'h143, 32'h77);
    rd_chk("R5", 12'h300, 32'h8A0);
    trap("R5", 1'b1, 5'd9, 1'b0, 0, 32'h600, 32'h2000);
    priv_chk("R5", 2'd1);
    rd_chk("R5", 12'h300, 32'h980);
    rd_chk("R5", 12'h141, 32'h600);
    xret("R9", 1'b0, 1'b1, 32'h600);
    priv_chk("R9", 2'd1);
    rd_chk("R9", 12'h300, 32'h8A0);
    xret("R8", 1'b1, 1'b0, 0);
    priv_chk("R8", 2'd1);
  endtask

  task automatic t_priority;
    @(negedge clk);
    trap_valid = 1; trap_irq = 0; trap_cause = 5'd3; trap_pc = 32'h700;
    mret = 1; csr_we = 1; csr_addr = 12'h340; csr_wdata = 32'h99;
    #1 chk("R12", "xret illegal", {31'b0, xret_illegal}, 32'd0);
    chk("R12", "redirect pc", redirect_pc, 32'h2000);
    @(negedge clk); trap_valid = 0; mret = 0; csr_we = 0;
    priv_chk("R12", 2'd1);
    rd_chk("R12", 12'h141, 32'h700);
    rd_chk("R12", 12'h142, 32'h3);
    rd_chk("R12", 12'h340, 32'h11);
    rd_chk("R12", 12'h300, 32'h980);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_csr_map();
    t_illegal();
    t_trap_m();
    t_mret();
    t_trap_s();
    t_irq_m();
    t_sret_m();
    t_irq_s();
    t_priority();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule